// File: doc/BRIEF.md
# Receive Serial Output Framer

This block sits between a receive demodulator and a MAC and hands demodulated header and payload bits to the MAC over a three-wire serial interface: a data line, a bit clock and a data-ready flag. The demodulator offers one bit per strobe pulse. It also signals when the start-of-frame delimiter has been found, when the header check has failed, and which bits belong to the header CRC-16 field. The receiver-enable input gates all activity.

Data-ready opens a frame when the delimiter is detected. The frame closes when the header is reported bad or when the receiver is put into standby. Inside a frame, each accepted bit is launched on the falling edge of the bit clock. The clock rises a fixed number of cycles later, and the MAC samples the bit on that rising edge. The clock stays low before the first bit of a frame and throughout the CRC-16 field, so the MAC sees no sampling edge for those bits. Bits keep their arrival order, so a least-significant-bit-first stream reaches the MAC unchanged.

One configuration bit inverts the bit clock. A second configuration bit inverts a channel-busy indication that passes straight through the block.

Top module: `rx_out_framer`

## Requirements
- R1: When `rx_en_i` is 1 and `hdr_err_i` is 0, a 1 on `sfd_det_i` sets `data_rdy_o` to 1 at the next clock edge. With `rx_en_i` at 0, `sfd_det_i` has no effect.
- R2: `data_rdy_o` clears at the edge after `rx_en_i` is 0 or `hdr_err_i` is 1. A header error wins over a delimiter detect in the same cycle.
- R3: While `data_rdy_o` is 0, the internal bit clock stays low: `bit_clk_o` equals `clk_inv_i`. Bit strobes in that state are ignored and `ser_d_o` stays 0.
- R4: A bit strobe accepted inside a frame puts `bit_i` on `ser_d_o` at the next edge and drives the internal clock low at that same edge. The clock goes high RISE_DLY edges later (default 2).
- R5: A bit accepted with `crc_fld_i` at 1 produces no rising clock edge. The internal clock stays low until a later non-CRC bit raises it.
- R6: Each non-CRC bit of a frame produces exactly one rising edge, and the values sampled at those edges appear in strobe order. This requires strobes to be spaced at least RISE_DLY+1 cycles apart.
- R7: With `clk_inv_i` at 1, `bit_clk_o` is the complement of the non-inverted bit clock.
- R8: `chan_busy_o` equals `chan_busy_i` XOR `busy_inv_i`. By default 0 means clear and 1 means busy.
- R9: When a frame closes, `ser_d_o` goes to 0 and the internal clock goes low at the same edge. A rising edge still pending for the last bit is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable; 0 means standby |
| bit_i | input | 1 | Demodulated bit |
| bit_vld_i | input | 1 | One-cycle strobe qualifying `bit_i` |
| sfd_det_i | input | 1 | Start-of-frame delimiter detected pulse |
| hdr_err_i | input | 1 | Header error pulse |
| crc_fld_i | input | 1 | Marks the current bit as part of the header CRC-16 |
| clk_inv_i | input | 1 | Bit clock polarity select |
| chan_busy_i | input | 1 | Raw channel-busy indication |
| busy_inv_i | input | 1 | Channel-busy polarity select |
| ser_d_o | output | 1 | Serial data to the MAC |
| bit_clk_o | output | 1 | Gated bit clock to the MAC |
| data_rdy_o | output | 1 | Frame active flag |
| chan_busy_o | output | 1 | Channel-busy indication after polarity select |

## Verification
A frame flag stuck in the wrong state shows on `data_rdy_o` one edge after the delimiter or drop input. A wrong launch register shows on `ser_d_o` one edge after a strobe. A miscounting rise timer or a CRC gate that fails to hold the clock shows as an extra, missing or early rising edge within RISE_DLY cycles. The bench acts as the MAC: it collects the bit sampled at every rising edge and compares the sequence against the non-CRC bits it sent, so one spurious or lost edge breaks the whole frame's comparison.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
  typedef struct packed {
    logic data;
    logic crc;
  } rxo_bit_t;
endpackage

// File: rtl/rxo_frame_ctl.sv
module rxo_frame_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_en_i,
  input  logic sfd_det_i,
  input  logic hdr_err_i,
  output logic act_o,
  output logic drop_o
);
  logic act_q;

  assign drop_o = !rx_en_i || hdr_err_i;
  assign act_o  = act_q;

  // drop has priority over a delimiter in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        act_q <= 1'b0;
    else if (drop_o)    act_q <= 1'b0;
    else if (sfd_det_i) act_q <= 1'b1;
  end

  // R1
  sfd_sets_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && !hdr_err_i && sfd_det_i) |=> act_q);
  // R2
  drop_clears_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i || hdr_err_i) |=> !act_q);
endmodule

// File: rtl/rxo_bit_launch.sv
module rxo_bit_launch
  import rxo_pkg::*;
#(
  parameter int unsigned RISE_DLY = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     act_i,
  input  logic     drop_i,
  input  logic     strb_i,
  input  rxo_bit_t bit_i,
  output logic     rxd_o,
  output logic     clk_o
);
  localparam int unsigned CNT_W = (RISE_DLY > 1) ? $clog2(RISE_DLY) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RISE_DLY - 1);

  rxo_bit_t         cur_q;
  logic             clk_q;
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign accept = act_i && !drop_i && strb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      clk_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (drop_i) begin
      cur_q  <= '0;
      clk_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      // launch on the falling edge
      cur_q  <= bit_i;
      clk_q  <= 1'b0;
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (pend_q) begin
      if (cnt_q == CNT_LAST) begin
        clk_q  <= !cur_q.crc;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rxd_o = cur_q.data;
  assign clk_o = clk_q;

  // R3
  idle_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |-> !clk_q);
  // R4
  launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (!clk_q && rxd_o == $past(bit_i.data)));
  // R5
  crc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q.crc |-> !clk_q);
  // R9
  drop_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> (!pend_q && !clk_q));
endmodule

// File: rtl/rx_out_framer.sv
module rx_out_framer
  import rxo_pkg::*;
#(
  parameter int unsigned RISE_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_en_i,
  input  logic bit_i,
  input  logic bit_vld_i,
  input  logic sfd_det_i,
  input  logic hdr_err_i,
  input  logic crc_fld_i,
  input  logic clk_inv_i,
  input  logic chan_busy_i,
  input  logic busy_inv_i,
  output logic ser_d_o,
  output logic bit_clk_o,
  output logic data_rdy_o,
  output logic chan_busy_o
);
  logic     act;
  logic     drop;
  logic     clk_raw;
  rxo_bit_t in_bit;

  assign in_bit = '{data: bit_i, crc: crc_fld_i};

  rxo_frame_ctl u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_en_i   (rx_en_i),
    .sfd_det_i (sfd_det_i),
    .hdr_err_i (hdr_err_i),
    .act_o     (act),
    .drop_o    (drop)
  );

  rxo_bit_launch #(.RISE_DLY(RISE_DLY)) u_launch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .drop_i (drop),
    .strb_i (bit_vld_i),
    .bit_i  (in_bit),
    .rxd_o  (ser_d_o),
    .clk_o  (clk_raw)
  );

  assign data_rdy_o  = act;
  assign bit_clk_o   = clk_raw ^ clk_inv_i;
  assign chan_busy_o = chan_busy_i ^ busy_inv_i;

  // R9
  idle_data_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_rdy_o |-> !ser_d_o);
endmodule

// File: tb/rx_out_framer_bench.sv
`timescale 1ns/1ps
module rx_out_framer_bench;
  localparam int RISE_DLY = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, bit_d = 1'b0, bit_vld = 1'b0, sfd = 1'b0, herr = 1'b0;
  logic crc = 1'b0, cinv = 1'b0, busy = 1'b0, binv = 1'b0;
  logic ser_d, bclk, rdy, busy_o;

  int n_run = 0, n_fail = 0;
  logic [0:255] exp_bits, mac_bits;
  int exp_cnt = 0, mac_cnt = 0;
  logic prev_eff = 1'b0;

  always #2.5 clk = ~clk;

  rx_out_framer #(.RISE_DLY(RISE_DLY)) u_rx_out_framer (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .bit_i(bit_d),
    .bit_vld_i(bit_vld), .sfd_det_i(sfd), .hdr_err_i(herr), .crc_fld_i(crc),
    .clk_inv_i(cinv), .chan_busy_i(busy), .busy_inv_i(binv),
    .ser_d_o(ser_d), .bit_clk_o(bclk), .data_rdy_o(rdy), .chan_busy_o(busy_o)
  );

  // MAC model: capture data at every rising edge of the de-inverted clock
  always @(negedge clk) begin
    if ((bclk ^ cinv) && !prev_eff) begin
      mac_bits[mac_cnt[7:0]] = ser_d;
      mac_cnt = mac_cnt + 1;
    end
    prev_eff = bclk ^ cinv;
  end

  function automatic logic exp_busy(logic b, logic inv);
    return inv ? !b : b;
  endfunction

  task automatic check(string req, logic act, logic expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic check_int(string req, int act, int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // send one bit; framed tells whether the bench expects it to be accepted
  task automatic send_bit(logic b, logic c, logic framed);
    bit_d = b; crc = c; bit_vld = 1'b1;
    step();
    bit_vld = 1'b0; crc = 1'b0;
    if (framed) begin
      // R4 launch: data present, clock low
      check("R4 data", ser_d, b);
      check("R4 clk low", bclk ^ cinv, 1'b0);
      if (!c) begin exp_bits[exp_cnt[7:0]] = b; exp_cnt++; end
    end else begin
      check("R3 ignored data", ser_d, 1'b0);
      check("R3 idle clk", bclk, cinv);
    end
    for (int i = 0; i < RISE_DLY - 1; i++) step();
    if (framed) check("R4 clk not early", bclk ^ cinv, 1'b0);
    step();
    if (framed) check(c ? "R5 crc clk low" : "R4 clk rise", bclk ^ cinv, !c);
    for (int i = 0; i < int'($urandom_range(0, 2)); i++) step();
  endtask

  task automatic run_frame(int nbits, int crc_lo, int crc_hi, bit end_en, logic inv);
    cinv = inv;
    step();
    exp_cnt = 0; mac_cnt = 0;
    send_bit(1'b1, 1'b0, 1'b0);
    check("R3 rdy low", rdy, 1'b0);
    sfd = 1'b1; step(); sfd = 1'b0;
    check("R1 rdy set", rdy, 1'b1);
    check("R3 clk low before first bit", bclk ^ cinv, 1'b0);
    check("R7 polarity", bclk, inv);
    for (int i = 0; i < nbits; i++)
      send_bit(1'($urandom), (i >= crc_lo && i < crc_hi), 1'b1);
    if (end_en) rx_en = 1'b0; else herr = 1'b1;
    step();
    rx_en = 1'b1; herr = 1'b0;
    check(end_en ? "R2 drop on standby" : "R2 drop on hdr err", rdy, 1'b0);
    check("R9 data low", ser_d, 1'b0);
    check("R9 clk idle", bclk, inv);
    check_int("R6 edge count", mac_cnt, exp_cnt);
    for (int i = 0; i < exp_cnt && i < mac_cnt; i++)
      check("R6 bit order", mac_bits[i], exp_bits[i]);
  endtask

  initial begin
    void'($urandom(32'd5171));
    repeat (3) step();
    check("R3 reset rdy", rdy, 1'b0);
    check("R3 reset data", ser_d, 1'b0);
    check("R3 reset clk", bclk, 1'b0);
    rst_n = 1'b1;
    step();

    // R1: delimiter ignored in standby
    sfd = 1'b1; step(); sfd = 1'b0;
    check("R1 sfd in standby", rdy, 1'b0);
    rx_en = 1'b1; step();

    // R2: header error beats delimiter
    sfd = 1'b1; herr = 1'b1; step(); sfd = 1'b0; herr = 1'b0;
    check("R2 err over sfd", rdy, 1'b0);

    // directed frames: CRC span, no CRC, inverted clock
    run_frame(16, 8, 12, 1'b0, 1'b0);
    run_frame(10, 99, 99, 1'b1, 1'b0);
    run_frame(12, 0, 4, 1'b0, 1'b1);

    // R9: pending rise cancelled by a drop right after launch
    cinv = 1'b0;
    sfd = 1'b1; step(); sfd = 1'b0;
    mac_cnt = 0;
    bit_d = 1'b1; bit_vld = 1'b1; step(); bit_vld = 1'b0;
    herr = 1'b1; step(); herr = 1'b0;
    repeat (RISE_DLY + 2) step();
    check_int("R9 cancelled rise", mac_cnt, 0);
    check("R9 data cleared", ser_d, 1'b0);

    // random frames
    for (int f = 0; f < 20; f++) begin
      int n, lo;
      n  = int'($urandom_range(4, 40));
      lo = int'($urandom_range(0, n));
      run_frame(n, lo, lo + int'($urandom_range(0, 16)),
                1'($urandom), 1'($urandom));
    end

    // R8: busy passthrough with polarity
    for (int i = 0; i < 16; i++) begin
      busy = 1'($urandom); binv = 1'($urandom);
      #1;
      check("R8 busy", busy_o, exp_busy(busy, binv));
      step();
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule